// File: doc/BRIEF.md
# Register-Offset Transaction Sequencer

This block turns a single register-offset access (a target device, a one-byte register offset, a direction, a data length and write data) into the ordered series of register writes and reads that a two-wire serial bus controller needs to carry it out. It first checks the request for shape. It then picks the command code that matches the direction and length. It drives the controller's register port one access per cycle, polls the controller's status word until the transfer ends or a poll budget runs out, and returns a status code together with any read data.

The controller only answers devices that hold a short run-time address. The block therefore remembers which device it last bound. When a request names a different device, it maps the device address to its run-time address through a fixed table and runs an address-assignment command before the data command. The remembered device changes only when that assignment step completes cleanly. A separate reset request pulses the controller's soft-reset bit and waits, within a bounded number of reads, for the bit to drop.

Top module: `bus_cmd_seq`

## Requirements
- R1: A request whose offset length is not 1, whose data length is not 1, 2 or 4 (including any value above 8), or whose two slave fields differ in bits [15:1] finishes with status 1 (invalid) and makes no register access.
- R2: The device address is the slave field shifted right by one. Device 0x3A3 maps to run-time address 0x2D, 0x745 to 0x3A and 0xE89 to 0x4E. Any other device finishes with status 2 (no device), makes no register access, and leaves the remembered device unchanged.
- R3: When the device differs from the remembered one, the block writes 0x7 to status (0x0C), then {rta in [23:16], device in [15:0]} to 0x30, then 0xE8 to command (0x2C), then 0x82 to control (0x00), and polls. It remembers the device only if that step succeeds. A failed step returns its error code, and the next request to that device repeats the step.
- R4: The data step writes 0x7 to 0x0C, then the offset to 0x10, then the masked data to 0x1C (writes only), then the command code to 0x2C, then 0x10 for a read or 0x00 for a write to 0x18, and then 0x82 to 0x00. A request to the remembered device begins directly with this step.
- R5: Command codes are 0x8B, 0x9C and 0xA6 for 1, 2 and 4 byte reads, and 0x4E, 0x59 and 0x63 for 1, 2 and 4 byte writes.
- R6: After each start, status (0x0C) is read until any of bits 0, 1 or 2 is set. If bit 0 is set the result is success (status 0). If only bit 1 or bit 2 is set the result is status 3 (I/O error). If no bit is set within POLL_LIMIT reads the result is status 4 (timeout).
- R7: A successful read fetches 0x1C and returns its low 1, 2 or 4 bytes with the upper bytes zero. Write data bytes beyond the length are written as zero.
- R8: A reset request writes 0x01 to 0x00, then reads 0x00 until bit 0 is clear. That ends with status 0; if the bit stays set for RESET_TRIES reads, the request ends with status 4.
- R9: reqReady is high only while no request is in progress. It drops on the cycle after acceptance, and no register access happens while it is high.
- R10: Each request produces exactly one single-cycle rspValid pulse. rspRdata is zero unless the result is a successful read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request accepted when reqValid is high |
| reqReset | input | 1 | Request is a controller soft reset |
| reqOffSlave | input | 16 | Slave field of the offset message |
| reqOffLen | input | 4 | Offset length in bytes |
| reqOffset | input | 8 | Register offset inside the device |
| reqDataSlave | input | 16 | Slave field of the data message |
| reqRead | input | 1 | 1 for read, 0 for write |
| reqDataLen | input | 4 | Data length in bytes |
| reqWdata | input | 32 | Write data, byte 0 in [7:0] |
| rspValid | output | 1 | One-cycle result pulse |
| rspStatus | output | 3 | 0 ok, 1 invalid, 2 no device, 3 I/O error, 4 timeout |
| rspRdata | output | 32 | Read data, zero-extended |
| regReq | output | 1 | Controller register access |
| regWe | output | 1 | Access is a write |
| regAddr | output | 6 | Controller register byte offset |
| regWdata | output | 32 | Controller register write data |
| regRdata | input | 32 | Controller read data, valid the cycle after a read access |

## Verification
The assertions take for granted that the controller returns read data on the clock edge after a read access. They also assume it keeps status bits set until a write-one-to-clear, and that request fields stay steady while reqValid waits for reqReady. The bench's behavioural controller answers every read on the following edge and clears status only on writes to 0x0C. Its tasks hold every request field until the handshake edge and lower reqValid straight after.

// File: rtl/bus_cmd_seq_pkg.sv
package bus_cmd_seq_pkg;

  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] REG_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] REG_STAT  = 6'h0C;
  localparam logic [ADDR_W-1:0] REG_DADDR = 6'h10;
  localparam logic [ADDR_W-1:0] REG_LEN   = 6'h18;
  localparam logic [ADDR_W-1:0] REG_DATA  = 6'h1C;
  localparam logic [ADDR_W-1:0] REG_CMD   = 6'h2C;
  localparam logic [ADDR_W-1:0] REG_DAR   = 6'h30;

  localparam logic [DATA_W-1:0] CTRL_GO    = 32'h0000_0082;
  localparam logic [DATA_W-1:0] CTRL_SRST  = 32'h0000_0001;
  localparam logic [DATA_W-1:0] STAT_ALL   = 32'h0000_0007;
  localparam logic [DATA_W-1:0] LEN_RDFLAG = 32'h0000_0010;
  localparam logic [7:0]        CMD_BIND   = 8'hE8;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_INVALID = 3'd1,
    RES_NODEV   = 3'd2,
    RES_IOERR   = 3'd3,
    RES_TIMEOUT = 3'd4
  } resultE;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_CLR_STAT,
    OP_WR_DAR,
    OP_WR_BIND,
    OP_WR_DADDR,
    OP_WR_DATA,
    OP_WR_CMD,
    OP_WR_LEN,
    OP_WR_GO,
    OP_WR_SRST,
    OP_RD_STAT,
    OP_RD_CTRL,
    OP_RD_DATA
  } busOpE;

  typedef struct packed {
    logic   capture;
    busOpE  op;
    logic   loadCache;
    logic   latchRd;
    logic   setResult;
    resultE result;
  } strobeT;

  typedef struct packed {
    logic isReset;
    logic reqOk;
    logic cacheHit;
    logic devKnown;
    logic isRead;
    logic statDone;
    logic statOver;
    logic srstBusy;
  } flagT;

  function automatic logic [7:0] rtaLookup(input logic [15:0] dev);
    case (dev)
      16'h03A3: rtaLookup = 8'h2D;
      16'h0745: rtaLookup = 8'h3A;
      16'h0E89: rtaLookup = 8'h4E;
      default:  rtaLookup = 8'h00;
    endcase
  endfunction

  function automatic logic isLegalRta(input logic [7:0] rta);
    case (rta)
      8'h17, 8'h2D, 8'h3A, 8'h4E, 8'h59, 8'h63, 8'h74, 8'h8B,
      8'h9C, 8'hA6, 8'hB1, 8'hC5, 8'hD2, 8'hE8, 8'hFF: isLegalRta = 1'b1;
      default: isLegalRta = 1'b0;
    endcase
  endfunction

  function automatic logic isCmdCode(input logic [7:0] code);
    case (code)
      8'hE8, 8'h8B, 8'h9C, 8'hA6, 8'h4E, 8'h59, 8'h63: isCmdCode = 1'b1;
      default: isCmdCode = 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] cmdFor(input logic rd, input logic [3:0] len);
    case ({rd, len})
      {1'b1, 4'd1}: cmdFor = 8'h8B;
      {1'b1, 4'd2}: cmdFor = 8'h9C;
      {1'b1, 4'd4}: cmdFor = 8'hA6;
      {1'b0, 4'd1}: cmdFor = 8'h4E;
      {1'b0, 4'd2}: cmdFor = 8'h59;
      default:      cmdFor = 8'h63;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] byteMask(input logic [3:0] len);
    case (len)
      4'd1:    byteMask = 32'h0000_00FF;
      4'd2:    byteMask = 32'h0000_FFFF;
      default: byteMask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/bus_cmd_seq_dp.sv
module bus_cmd_seq_dp
  import bus_cmd_seq_pkg::*;
#(
  parameter int unsigned SLAVE_W = 16,
  parameter int unsigned LEN_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobe,
  output flagT                flags,
  input  logic                reqReset,
  input  logic [SLAVE_W-2:0]  reqOffDev,
  input  logic [LEN_W-1:0]    reqOffLen,
  input  logic [7:0]          reqOffset,
  input  logic [SLAVE_W-2:0]  reqDataDev,
  input  logic                reqRead,
  input  logic [LEN_W-1:0]    reqDataLen,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                regReq,
  output logic                regWe,
  output logic [ADDR_W-1:0]   regAddr,
  output logic [DATA_W-1:0]   regWdata,
  input  logic [DATA_W-1:0]   regRdata,
  output logic [2:0]          rspStatus,
  output logic [DATA_W-1:0]   rspRdata
);

  localparam int unsigned DEV_W = SLAVE_W - 1;

  logic               capReset;
  logic [DEV_W-1:0]   capOffDev;
  logic [LEN_W-1:0]   capOffLen;
  logic [7:0]         capOffset;
  logic [DEV_W-1:0]   capDataDev;
  logic               capRead;
  logic [LEN_W-1:0]   capDataLen;
  logic [DATA_W-1:0]  capWdata;

  logic               cacheValid;
  logic [DEV_W-1:0]   cacheDev;
  resultE             resultReg;

  logic [15:0]        darDev;
  logic [7:0]         rta;
  logic               lenOk;
  logic [DATA_W-1:0]  dataMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capReset   <= 1'b0;
      capOffDev  <= '0;
      capOffLen  <= '0;
      capOffset  <= '0;
      capDataDev <= '0;
      capRead    <= 1'b0;
      capDataLen <= '0;
      capWdata   <= '0;
    end else if (strobe.capture) begin
      capReset   <= reqReset;
      capOffDev  <= reqOffDev;
      capOffLen  <= reqOffLen;
      capOffset  <= reqOffset;
      capDataDev <= reqDataDev;
      capRead    <= reqRead;
      capDataLen <= reqDataLen;
      capWdata   <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cacheValid <= 1'b0;
      cacheDev   <= '0;
    end else if (strobe.loadCache) begin
      cacheValid <= 1'b1;
      cacheDev   <= capOffDev;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultReg <= RES_OK;
      rspRdata  <= '0;
    end else begin
      if (strobe.capture) rspRdata <= '0;
      else if (strobe.latchRd) rspRdata <= regRdata & dataMask;
      if (strobe.setResult) resultReg <= strobe.result;
    end
  end

  assign rspStatus = resultReg;
  assign darDev    = 16'(capOffDev);
  assign rta       = rtaLookup(darDev);
  assign dataMask  = byteMask(capDataLen);
  assign lenOk     = (capDataLen == LEN_W'(1)) || (capDataLen == LEN_W'(2)) ||
                     (capDataLen == LEN_W'(4));

  always_comb begin
    flags          = '0;
    flags.isReset  = capReset;
    flags.reqOk    = (capOffLen == LEN_W'(1)) && lenOk && (capOffDev == capDataDev);
    flags.cacheHit = cacheValid && (cacheDev == capOffDev);
    flags.devKnown = (rta != 8'h00);
    flags.isRead   = capRead;
    flags.statDone = |(regRdata & STAT_ALL);
    flags.statOver = regRdata[0];
    flags.srstBusy = regRdata[0];
  end

  always_comb begin
    regReq   = 1'b1;
    regWe    = 1'b1;
    regAddr  = REG_CTRL;
    regWdata = '0;
    case (strobe.op)
      OP_CLR_STAT: begin regAddr = REG_STAT;  regWdata = STAT_ALL; end
      OP_WR_DAR:   begin regAddr = REG_DAR;   regWdata = {8'h00, rta, darDev}; end
      OP_WR_BIND:  begin regAddr = REG_CMD;   regWdata = {24'h0, CMD_BIND}; end
      OP_WR_DADDR: begin regAddr = REG_DADDR; regWdata = {24'h0, capOffset}; end
      OP_WR_DATA:  begin regAddr = REG_DATA;  regWdata = capWdata & dataMask; end
      OP_WR_CMD:   begin regAddr = REG_CMD;   regWdata = {24'h0, cmdFor(capRead, capDataLen)}; end
      OP_WR_LEN:   begin
        regAddr  = REG_LEN;
        regWdata = DATA_W'(LEN_W'(capOffLen - LEN_W'(1))) | (capRead ? LEN_RDFLAG : '0);
      end
      OP_WR_GO:    begin regAddr = REG_CTRL;  regWdata = CTRL_GO; end
      OP_WR_SRST:  begin regAddr = REG_CTRL;  regWdata = CTRL_SRST; end
      OP_RD_STAT:  begin regWe = 1'b0; regAddr = REG_STAT; end
      OP_RD_CTRL:  begin regWe = 1'b0; regAddr = REG_CTRL; end
      OP_RD_DATA:  begin regWe = 1'b0; regAddr = REG_DATA; end
      default:     begin regReq = 1'b0; regWe = 1'b0; end
    endcase
  end

endmodule

// File: rtl/bus_cmd_seq_ctrl.sv
module bus_cmd_seq_ctrl
  import bus_cmd_seq_pkg::*;
#(
  parameter int unsigned POLL_LIMIT  = 1000,
  parameter int unsigned RESET_TRIES = 100
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  output logic   reqReady,
  output logic   rspValid,
  input  flagT   flags,
  output strobeT strobe
);

  localparam int unsigned MAX_WAIT = (POLL_LIMIT > RESET_TRIES) ? POLL_LIMIT : RESET_TRIES;
  localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);

  typedef enum logic [4:0] {
    S_IDLE, S_CHECK,
    S_RST_WR, S_RST_RD, S_RST_CHK,
    S_SR_CLR, S_SR_DAR, S_SR_CMD,
    S_D_CLR, S_D_ADDR, S_D_DATA, S_D_CMD, S_D_LEN,
    S_START, S_POLL_RD, S_POLL_CHK,
    S_DATA_RD, S_DATA_CHK,
    S_DONE
  } stateE;

  stateE            state, stateNext;
  logic [CNT_W-1:0] waitCnt;
  logic             cntClr, cntInc;
  logic             bindPhase;
  logic             phaseSet, phaseClr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      waitCnt   <= '0;
      bindPhase <= 1'b0;
    end else begin
      state <= stateNext;
      if (cntClr) waitCnt <= '0;
      else if (cntInc) waitCnt <= waitCnt + CNT_W'(1);
      if (phaseSet) bindPhase <= 1'b1;
      else if (phaseClr) bindPhase <= 1'b0;
    end
  end

  assign reqReady = (state == S_IDLE);
  assign rspValid = (state == S_DONE);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    cntClr    = 1'b0;
    cntInc    = 1'b0;
    phaseSet  = 1'b0;
    phaseClr  = 1'b0;
    case (state)
      S_IDLE: if (reqValid) begin
        strobe.capture = 1'b1;
        stateNext      = S_CHECK;
      end
      S_CHECK: begin
        if (flags.isReset) stateNext = S_RST_WR;
        else if (!flags.reqOk) begin
          strobe.setResult = 1'b1;
          strobe.result    = RES_INVALID;
          stateNext        = S_DONE;
        end else if (flags.cacheHit) stateNext = S_D_CLR;
        else if (!flags.devKnown) begin
          strobe.setResult = 1'b1;
          strobe.result    = RES_NODEV;
          stateNext        = S_DONE;
        end else stateNext = S_SR_CLR;
      end
      S_RST_WR: begin
        strobe.op = OP_WR_SRST;
        cntClr    = 1'b1;
        stateNext = S_RST_RD;
      end
      S_RST_RD: begin
        strobe.op = OP_RD_CTRL;
        stateNext = S_RST_CHK;
      end
      S_RST_CHK: begin
        if (!flags.srstBusy) begin
          strobe.setResult = 1'b1;
          strobe.result    = RES_OK;
          stateNext        = S_DONE;
        end else if (waitCnt == CNT_W'(RESET_TRIES - 1)) begin
          strobe.setResult = 1'b1;
          strobe.result    = RES_TIMEOUT;
          stateNext        = S_DONE;
        end else begin
          cntInc    = 1'b1;
          stateNext = S_RST_RD;
        end
      end
      S_SR_CLR: begin
        strobe.op = OP_CLR_STAT;
        phaseSet  = 1'b1;
        stateNext = S_SR_DAR;
      end
      S_SR_DAR: begin
        strobe.op = OP_WR_DAR;
        stateNext = S_SR_CMD;
      end
      S_SR_CMD: begin
        strobe.op = OP_WR_BIND;
        stateNext = S_START;
      end
      S_D_CLR: begin
        strobe.op = OP_CLR_STAT;
        phaseClr  = 1'b1;
        stateNext = S_D_ADDR;
      end
      S_D_ADDR: begin
        strobe.op = OP_WR_DADDR;
        stateNext = flags.isRead ? S_D_CMD : S_D_DATA;
      end
      S_D_DATA: begin
        strobe.op = OP_WR_DATA;
        stateNext = S_D_CMD;
      end
      S_D_CMD: begin
        strobe.op = OP_WR_CMD;
        stateNext = S_D_LEN;
      end
      S_D_LEN: begin
        strobe.op = OP_WR_LEN;
        stateNext = S_START;
      end
      S_START: begin
        strobe.op = OP_WR_GO;
        cntClr    = 1'b1;
        stateNext = S_POLL_RD;
      end
      S_POLL_RD: begin
        strobe.op = OP_RD_STAT;
        stateNext = S_POLL_CHK;
      end
      S_POLL_CHK: begin
        if (flags.statDone) begin
          if (!flags.statOver) begin
            strobe.setResult = 1'b1;
            strobe.result    = RES_IOERR;
            stateNext        = S_DONE;
          end else if (bindPhase) begin
            strobe.loadCache = 1'b1;
            stateNext        = S_D_CLR;
          end else if (flags.isRead) stateNext = S_DATA_RD;
          else begin
            strobe.setResult = 1'b1;
            strobe.result    = RES_OK;
            stateNext        = S_DONE;
          end
        end else if (waitCnt == CNT_W'(POLL_LIMIT - 1)) begin
          strobe.setResult = 1'b1;
          strobe.result    = RES_TIMEOUT;
          stateNext        = S_DONE;
        end else begin
          cntInc    = 1'b1;
          stateNext = S_POLL_RD;
        end
      end
      S_DATA_RD: begin
        strobe.op = OP_RD_DATA;
        stateNext = S_DATA_CHK;
      end
      S_DATA_CHK: begin
        strobe.latchRd   = 1'b1;
        strobe.setResult = 1'b1;
        strobe.result    = RES_OK;
        stateNext        = S_DONE;
      end
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/bus_cmd_seq.sv
module bus_cmd_seq
  import bus_cmd_seq_pkg::*;
#(
  parameter int unsigned SLAVE_W     = 16,
  parameter int unsigned LEN_W       = 4,
  parameter int unsigned POLL_LIMIT  = 1000,
  parameter int unsigned RESET_TRIES = 100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqReset,
  input  logic [SLAVE_W-1:0] reqOffSlave,
  input  logic [LEN_W-1:0]   reqOffLen,
  input  logic [7:0]         reqOffset,
  input  logic [SLAVE_W-1:0] reqDataSlave,
  input  logic               reqRead,
  input  logic [LEN_W-1:0]   reqDataLen,
  input  logic [31:0]        reqWdata,
  output logic               rspValid,
  output logic [2:0]         rspStatus,
  output logic [31:0]        rspRdata,
  output logic               regReq,
  output logic               regWe,
  output logic [5:0]         regAddr,
  output logic [31:0]        regWdata,
  input  logic [31:0]        regRdata
);

  strobeT strobe;
  flagT   flags;
  logic   unusedSlaveLsb;

  assign unusedSlaveLsb = reqOffSlave[0] ^ reqDataSlave[0];

  bus_cmd_seq_ctrl #(
    .POLL_LIMIT (POLL_LIMIT),
    .RESET_TRIES(RESET_TRIES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .rspValid(rspValid),
    .flags   (flags),
    .strobe  (strobe)
  );

  bus_cmd_seq_dp #(
    .SLAVE_W(SLAVE_W),
    .LEN_W  (LEN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .flags     (flags),
    .reqReset  (reqReset),
    .reqOffDev (reqOffSlave[SLAVE_W-1:1]),
    .reqOffLen (reqOffLen),
    .reqOffset (reqOffset),
    .reqDataDev(reqDataSlave[SLAVE_W-1:1]),
    .reqRead   (reqRead),
    .reqDataLen(reqDataLen),
    .reqWdata  (reqWdata),
    .regReq    (regReq),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .rspStatus (rspStatus),
    .rspRdata  (rspRdata)
  );

endmodule

// File: rtl/bus_cmd_seq_chk.sv
module bus_cmd_seq_chk
  import bus_cmd_seq_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        rspValid,
  input logic [2:0]  rspStatus,
  input logic [31:0] rspRdata,
  input logic        regReq,
  input logic        regWe,
  input logic [5:0]  regAddr,
  input logic [31:0] regWdata
);

  // R9: an accepted request closes the door on the next cycle
  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R9: the register port is quiet whenever the block is idle
  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !regReq);

  // R10: result pulse lasts one cycle
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R10: no read data accompanies a failed result
  p_zero_data_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus != 3'd0) |-> (rspRdata == 32'h0));

  // R6: result code stays inside the defined set
  p_code_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspStatus <= 3'd4));

  // R3: address assignment only carries a legal run-time address
  p_legal_rta_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regWe && regAddr == REG_DAR) |->
      (regWdata[31:24] == 8'h00 && isLegalRta(regWdata[23:16])));

  // R5: command register only receives a defined code
  p_cmd_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regWe && regAddr == REG_CMD) |->
      (regWdata[31:8] == 24'h0 && isCmdCode(regWdata[7:0])));

endmodule

bind bus_cmd_seq bus_cmd_seq_chk u_chk (.*);

// File: tb/bus_cmd_seq_tb.sv
`timescale 1ns/1ps
module bus_cmd_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqReset = 1'b0;
  logic [15:0] reqOffSlave = '0;
  logic [3:0]  reqOffLen = '0;
  logic [7:0]  reqOffset = '0;
  logic [15:0] reqDataSlave = '0;
  logic        reqRead = 1'b0;
  logic [3:0]  reqDataLen = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [2:0]  rspStatus;
  logic [31:0] rspRdata;
  logic        regReq;
  logic        regWe;
  logic [5:0]  regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;

  int checks = 0;
  int fails  = 0;
  int holdBad = 0;
  int pulseBad = 0;

  always #4 clk = ~clk;

  bus_cmd_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqReset(reqReset), .reqOffSlave(reqOffSlave), .reqOffLen(reqOffLen),
    .reqOffset(reqOffset), .reqDataSlave(reqDataSlave), .reqRead(reqRead),
    .reqDataLen(reqDataLen), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspStatus(rspStatus), .rspRdata(rspRdata), .regReq(regReq), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  // behavioural controller
  int bindMode = 0;   // 0 done, 1 error bit, 2 busy-load bit, 3 never
  int dataMode = 0;
  int rstDelay = 3;
  bit rstHang  = 1'b0;
  logic [31:0] mdlData = 32'h1122_3344;

  logic [31:0] statReg;
  logic [7:0]  cmdReg;
  logic        srBusy;
  int          rstLeft;
  logic        pending;
  int          goDly;
  logic        goIsBind;
  logic [5:0]  logAddr [0:511];
  logic [31:0] logData [0:511];
  int          logCnt;
  int          statReads;
  int          ctrlReads;

  always @(posedge clk) begin
    if (!rstN) begin
      statReg <= '0; cmdReg <= '0; srBusy <= 1'b0; rstLeft <= 0;
      pending <= 1'b0; goDly <= 0; goIsBind <= 1'b0; regRdata <= '0;
      logCnt <= 0; statReads <= 0; ctrlReads <= 0;
    end else begin
      if (pending) begin
        if (goDly == 0) begin
          pending <= 1'b0;
          case (goIsBind ? bindMode : dataMode)
            0: statReg <= statReg | 32'h1;
            1: statReg <= statReg | 32'h2;
            2: statReg <= statReg | 32'h4;
            default: ;
          endcase
        end else goDly <= goDly - 1;
      end
      if (regReq && regWe) begin
        logAddr[logCnt % 512] <= regAddr;
        logData[logCnt % 512] <= regWdata;
        logCnt <= logCnt + 1;
        case (regAddr)
          6'h0C: statReg <= statReg & ~regWdata;
          6'h2C: cmdReg <= regWdata[7:0];
          6'h00: begin
            if (regWdata[7]) begin
              pending <= 1'b1; goDly <= 3; goIsBind <= (cmdReg == 8'hE8);
            end
            if (regWdata[0]) begin srBusy <= 1'b1; rstLeft <= rstDelay; end
          end
          default: ;
        endcase
      end
      if (regReq && !regWe) begin
        case (regAddr)
          6'h0C: begin regRdata <= statReg; statReads <= statReads + 1; end
          6'h00: begin
            regRdata <= {31'h0, srBusy};
            ctrlReads <= ctrlReads + 1;
            if (rstLeft > 0) rstLeft <= rstLeft - 1;
            else if (!rstHang) srBusy <= 1'b0;
          end
          6'h1C: regRdata <= mdlData;
          default: regRdata <= '0;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runReq(input bit isRst, input logic [15:0] oSl, input logic [3:0] oLen,
                        input logic [7:0] off, input logic [15:0] dSl, input bit rd,
                        input logic [3:0] dLen, input logic [31:0] wd,
                        output logic [2:0] st, output logic [31:0] rdat);
    @(negedge clk);
    reqReset = isRst; reqOffSlave = oSl; reqOffLen = oLen; reqOffset = off;
    reqDataSlave = dSl; reqRead = rd; reqDataLen = dLen; reqWdata = wd;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid) begin
      if (reqReady) holdBad++;
      @(negedge clk);
    end
    st = rspStatus;
    rdat = rspRdata;
    @(negedge clk);
    if (rspValid) pulseBad++;
  endtask

  task automatic expWr(input int base, input int idx, input logic [5:0] a,
                       input logic [31:0] d, input string tag);
    chk({tag, " addr"}, 32'(logAddr[(base + idx) % 512]), 32'(a));
    chk({tag, " data"}, logData[(base + idx) % 512], d);
  endtask

  task automatic t_reset_state();
    chk("R9 ready after reset", 32'(reqReady), 32'd1);
    chk("R10 no pulse after reset", 32'(rspValid), 32'd0);
    chk("R9 bus idle after reset", 32'(regReq), 32'd0);
  endtask

  task automatic t_invalid();
    logic [2:0] st; logic [31:0] rd; int b;
    b = logCnt;
    runReq(0, 16'h0746, 4'd2, 8'h01, 16'h0746, 0, 4'd1, 32'h0, st, rd);
    chk("R1 offset length 2", 32'(st), 32'd1);
    runReq(0, 16'h0746, 4'd1, 8'h01, 16'h0746, 1, 4'd3, 32'h0, st, rd);
    chk("R1 data length 3", 32'(st), 32'd1);
    runReq(0, 16'h0746, 4'd1, 8'h01, 16'h0746, 0, 4'd9, 32'h0, st, rd);
    chk("R1 data length 9", 32'(st), 32'd1);
    runReq(0, 16'h0746, 4'd1, 8'h01, 16'h0E8A, 0, 4'd1, 32'h0, st, rd);
    chk("R1 slave mismatch", 32'(st), 32'd1);
    chk("R10 rdata zero on reject", rd, 32'h0);
    chk("R1 no register access", 32'(logCnt - b), 32'd0);
  endtask

  task automatic t_first_write();
    logic [2:0] st; logic [31:0] rd; int b;
    b = logCnt;
    runReq(0, 16'h0746, 4'd1, 8'h12, 16'h0747, 0, 4'd2, 32'hAABBCCDD, st, rd);
    chk("R3 first write status", 32'(st), 32'd0);
    chk("R3 write count", 32'(logCnt - b), 32'd10);
    expWr(b, 0, 6'h0C, 32'h7, "R3 clear");
    expWr(b, 1, 6'h30, 32'h002D03A3, "R3 dar");
    expWr(b, 2, 6'h2C, 32'hE8, "R3 bind cmd");
    expWr(b, 3, 6'h00, 32'h82, "R3 go");
    expWr(b, 4, 6'h0C, 32'h7, "R4 clear");
    expWr(b, 5, 6'h10, 32'h12, "R4 offset");
    expWr(b, 6, 6'h1C, 32'h0000CCDD, "R7 masked data");
    expWr(b, 7, 6'h2C, 32'h59, "R5 wr16");
    expWr(b, 8, 6'h18, 32'h0, "R4 len write");
    expWr(b, 9, 6'h00, 32'h82, "R4 go");
  endtask

  task automatic t_cached_read();
    logic [2:0] st; logic [31:0] rd; int b;
    mdlData = 32'h11223344;
    b = logCnt;
    runReq(0, 16'h0746, 4'd1, 8'h34, 16'h0747, 1, 4'd4, 32'hFFFF_FFFF, st, rd);
    chk("R4 cached read status", 32'(st), 32'd0);
    chk("R7 read32 data", rd, 32'h11223344);
    chk("R4 cached write count", 32'(logCnt - b), 32'd5);
    expWr(b, 0, 6'h0C, 32'h7, "R4 clear");
    expWr(b, 1, 6'h10, 32'h34, "R4 offset");
    expWr(b, 2, 6'h2C, 32'hA6, "R5 rd32");
    expWr(b, 3, 6'h18, 32'h10, "R4 len read");
    expWr(b, 4, 6'h00, 32'h82, "R4 go");
    b = logCnt;
    runReq(0, 16'h0746, 4'd1, 8'h01, 16'h0747, 1, 4'd1, 32'h0, st, rd);
    chk("R7 read8 data", rd, 32'h44);
    expWr(b, 2, 6'h2C, 32'h8B, "R5 rd8");
    b = logCnt;
    runReq(0, 16'h0746, 4'd1, 8'h01, 16'h0747, 1, 4'd2, 32'h0, st, rd);
    chk("R7 read16 data", rd, 32'h3344);
    expWr(b, 2, 6'h2C, 32'h9C, "R5 rd16");
    b = logCnt;
    runReq(0, 16'h0746, 4'd1, 8'h05, 16'h0746, 0, 4'd1, 32'h123456DD, st, rd);
    chk("R10 write rdata zero", rd, 32'h0);
    expWr(b, 2, 6'h1C, 32'hDD, "R7 masked byte");
    expWr(b, 3, 6'h2C, 32'h4E, "R5 wr8");
    b = logCnt;
    runReq(0, 16'h0746, 4'd1, 8'h05, 16'h0746, 0, 4'd4, 32'h0BADF00D, st, rd);
    expWr(b, 2, 6'h1C, 32'h0BADF00D, "R7 full word");
    expWr(b, 3, 6'h2C, 32'h63, "R5 wr32");
  endtask

  task automatic t_switch();
    logic [2:0] st; logic [31:0] rd; int b;
    b = logCnt;
    runReq(0, 16'h0E8A, 4'd1, 8'h00, 16'h0E8A, 0, 4'd1, 32'h1, st, rd);
    chk("R2 dev 745 status", 32'(st), 32'd0);
    expWr(b, 1, 6'h30, 32'h003A0745, "R2 dar 745");
    b = logCnt;
    runReq(0, 16'h1D12, 4'd1, 8'h00, 16'h1D13, 0, 4'd1, 32'h1, st, rd);
    expWr(b, 1, 6'h30, 32'h004E0E89, "R2 dar E89");
    b = logCnt;
    runReq(0, 16'h0246, 4'd1, 8'h00, 16'h0246, 0, 4'd1, 32'h1, st, rd);
    chk("R2 unknown device", 32'(st), 32'd2);
    chk("R2 unknown no access", 32'(logCnt - b), 32'd0);
    b = logCnt;
    runReq(0, 16'h1D12, 4'd1, 8'h07, 16'h1D12, 0, 4'd1, 32'h1, st, rd);
    chk("R2 cache kept", 32'(logCnt - b), 32'd6);
    expWr(b, 1, 6'h10, 32'h07, "R4 no rebind");
  endtask

  task automatic t_errors();
    logic [2:0] st; logic [31:0] rd; int s;
    dataMode = 1;
    runReq(0, 16'h1D12, 4'd1, 8'h07, 16'h1D12, 1, 4'd4, 32'h0, st, rd);
    chk("R6 error bit", 32'(st), 32'd3);
    chk("R10 rdata zero on error", rd, 32'h0);
    dataMode = 2;
    runReq(0, 16'h1D12, 4'd1, 8'h07, 16'h1D12, 0, 4'd1, 32'h0, st, rd);
    chk("R6 busy-load bit", 32'(st), 32'd3);
    dataMode = 3;
    s = statReads;
    runReq(0, 16'h1D12, 4'd1, 8'h07, 16'h1D12, 0, 4'd1, 32'h0, st, rd);
    chk("R6 timeout", 32'(st), 32'd4);
    chk("R6 poll count", 32'(statReads - s), 32'd1000);
    dataMode = 0;
  endtask

  task automatic t_bind_fail();
    logic [2:0] st; logic [31:0] rd; int b;
    bindMode = 1;
    b = logCnt;
    runReq(0, 16'h0746, 4'd1, 8'h09, 16'h0746, 0, 4'd1, 32'h5, st, rd);
    chk("R3 bind error status", 32'(st), 32'd3);
    chk("R3 stop after bind", 32'(logCnt - b), 32'd4);
    bindMode = 0;
    b = logCnt;
    runReq(0, 16'h0746, 4'd1, 8'h09, 16'h0746, 0, 4'd1, 32'h5, st, rd);
    chk("R3 retry status", 32'(st), 32'd0);
    chk("R3 bind repeated", 32'(logCnt - b), 32'd10);
    expWr(b, 1, 6'h30, 32'h002D03A3, "R3 dar again");
  endtask

  task automatic t_soft_reset();
    logic [2:0] st; logic [31:0] rd; int b; int c;
    rstDelay = 3; rstHang = 1'b0;
    b = logCnt; c = ctrlReads;
    runReq(1, 16'h0, 4'd0, 8'h0, 16'h0, 0, 4'd0, 32'h0, st, rd);
    chk("R8 reset ok", 32'(st), 32'd0);
    chk("R8 one write", 32'(logCnt - b), 32'd1);
    expWr(b, 0, 6'h00, 32'h1, "R8 soft reset");
    chk("R8 read count", 32'(ctrlReads - c), 32'd5);
    rstHang = 1'b1;
    c = ctrlReads;
    runReq(1, 16'h0, 4'd0, 8'h0, 16'h0, 0, 4'd0, 32'h0, st, rd);
    chk("R8 reset timeout", 32'(st), 32'd4);
    chk("R8 retry limit", 32'(ctrlReads - c), 32'd100);
    rstHang = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_invalid();
    t_first_write();
    t_cached_read();
    t_switch();
    t_errors();
    t_bind_fail();
    t_soft_reset();
    chk("R9 ready held low while busy", 32'(holdBad), 32'd0);
    chk("R10 single pulse", 32'(pulseBad), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule